// File: doc/BRIEF.md
# Registered Product-Term Macrocell Array

This block is a small programmable sum-of-products array. Eight primary inputs drive a wide programmable AND plane. Four macrocells each take the OR of exactly three product terms, then apply an optional output inversion. Each macrocell output comes either straight from that logic or from a D register clocked by `clk_i`.

A pool of four shared expander terms adds product terms. Each expander is a product of the primary inputs. Its complement is fed back as an extra literal into every macrocell term. A function that needs more than three terms can therefore be folded into a "sum of products of products". The cost is a second pass through the AND plane. The output inversion lets a designer build the complement of a function when the complement needs fewer terms.

All fuses sit in one 360-bit configuration chain, loaded serially through a shift port. Expanders are evaluated from the inputs alone, so the feedback path has no combinational loop.

Top module: `pt_macro_array`

## Requirements
- R1: While `cfg_en_i` is high, each rising clock edge shifts `cfg_din_i` into chain bit 359 and moves every other bit one place toward bit 0. After 360 such edges the first bit shifted in sits at bit 0. While `cfg_en_i` is low, the chain holds its contents whatever `cfg_din_i` does.
- R2: Each literal of a product term has a 2-bit fuse. Code 00 leaves the literal out, 01 uses it true, 10 uses it complemented, and 11 forces the whole term to 0.
- R3: A product term whose fuses are all 00 evaluates to 1. After reset, with the cleared chain, every output becomes 1 at the first clock edge.
- R4: The combinational value of a macrocell is the OR of its three product terms, XORed with its inversion bit.
- R5: Expander e is the complement of the AND of its literals over the eight inputs. It appears as literal 8+e of every macrocell term. An expander with all fuses 00 gives 0.
- R6: When a macrocell's inversion bit is 1, its output is the complement of the OR of its terms.
- R7: When a macrocell's bypass bit is 1, its output follows the inputs in the same cycle. When the bit is 0, the output shows the value computed from the inputs at the previous rising edge.
- R8: While `rst_ni` is low, the configuration chain and all output registers are cleared, and `out_o` reads 0.
- R9: Chain layout. Bits 0..63 hold the expanders, 16 bits each, with expander e at 16*e and its input-j fuse at 16*e+2*j. Macrocell m starts at base 64+74*m. Its term t, literal j (j=0..11; 0..7 are inputs, 8..11 are expanders) sits at base+24*t+2*j. The inversion bit is at base+72 and the bypass bit at base+73.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the chain and the output registers |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_en_i | input | 1 | Shift enable of the configuration chain |
| cfg_din_i | input | 1 | Serial configuration data |
| in_i | input | 8 | Primary inputs to the AND plane |
| out_o | output | 4 | Macrocell outputs |

## Verification
A fuse shifted into the wrong slot changes the function a macrocell computes. A misplaced bit in the chain therefore shows up as a wrong `out_o` bit on the first input pattern that sensitises that literal. Each configuration is swept over many inputs so that such a pattern comes quickly. A wrong expander polarity corrupts every term that uses it, and the two folded example functions expose it within their 16-pattern sweep. A bad output register shows one cycle late or with a stale value on the first input change of a registered macrocell.

// File: rtl/pt_array_pkg.sv
package pt_array_pkg;
  typedef enum logic [1:0] {
    LIT_OFF  = 2'b00,
    LIT_POS  = 2'b01,
    LIT_NEG  = 2'b10,
    LIT_KILL = 2'b11
  } lit_fuse_e;
endpackage

// File: rtl/pt_cfg_chain.sv
module pt_cfg_chain #(
  parameter int W = 360
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         din_i,
  output logic [W-1:0] cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_o <= '0;
    else if (en_i) cfg_o <= {din_i, cfg_o[W-1:1]};
  end

  p_shift_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (cfg_o[W-1] == $past(din_i)) && (cfg_o[W-2:0] == $past(cfg_o[W-1:1])));
  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cfg_o));
endmodule

// File: rtl/pt_term.sv
module pt_term
  import pt_array_pkg::*;
#(
  parameter int N_LIT = 8
) (
  input  logic [2*N_LIT-1:0] fuse_i,
  input  logic [N_LIT-1:0]   lit_i,
  output logic               term_o
);
  always_comb begin
    term_o = 1'b1;
    for (int j = 0; j < N_LIT; j++) begin
      case (lit_fuse_e'(fuse_i[2*j +: 2]))
        LIT_POS:  term_o = term_o & lit_i[j];
        LIT_NEG:  term_o = term_o & ~lit_i[j];
        LIT_KILL: term_o = 1'b0;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/pt_macrocell.sv
module pt_macrocell #(
  parameter int N_LIT  = 12,
  parameter int N_TERM = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_TERM*2*N_LIT-1:0] fuse_i,
  input  logic                      inv_i,
  input  logic                      byp_i,
  input  logic [N_LIT-1:0]          lit_i,
  output logic                      out_o
);
  localparam int TW = 2 * N_LIT;

  logic [N_TERM-1:0] term;
  logic              comb;
  logic              q;

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    pt_term #(.N_LIT(N_LIT)) u_term (
      .fuse_i(fuse_i[t*TW +: TW]),
      .lit_i (lit_i),
      .term_o(term[t])
    );
  end

  assign comb = (|term) ^ inv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= 1'b0;
    else         q <= comb;
  end

  assign out_o = byp_i ? comb : q;

  function automatic logic any_kill(input logic [TW-1:0] f);
    any_kill = 1'b0;
    for (int j = 0; j < N_LIT; j++)
      if (f[2*j +: 2] == 2'b11) any_kill = 1'b1;
  endfunction

  for (genvar t = 0; t < N_TERM; t++) begin : g_chk
    p_kill_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      any_kill(fuse_i[t*TW +: TW]) |-> !term[t]);
    p_empty_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fuse_i[t*TW +: TW] == '0) |-> term[t]);
  end

  p_reg_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byp_i && $past(rst_ni)) |-> (out_o == $past((|term) ^ inv_i)));
endmodule

// File: rtl/pt_macro_array.sv
module pt_macro_array #(
  parameter int N_IN   = 8,
  parameter int N_MC   = 4,
  parameter int N_EXP  = 4,
  parameter int N_TERM = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_en_i,
  input  logic            cfg_din_i,
  input  logic [N_IN-1:0] in_i,
  output logic [N_MC-1:0] out_o
);
  localparam int N_LIT    = N_IN + N_EXP;
  localparam int EXP_FW   = 2 * N_IN;
  localparam int EXP_BITS = N_EXP * EXP_FW;
  localparam int MC_FW    = N_TERM * 2 * N_LIT;
  localparam int MC_BITS  = MC_FW + 2;
  localparam int CFG_W    = EXP_BITS + N_MC * MC_BITS;

  logic [CFG_W-1:0] cfg;
  logic [N_EXP-1:0] exp_term;
  logic [N_EXP-1:0] exp_n;
  logic [N_LIT-1:0] lit_all;

  pt_cfg_chain #(.W(CFG_W)) u_chain (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (cfg_en_i),
    .din_i (cfg_din_i),
    .cfg_o (cfg)
  );

  // first pass: expanders see the primary inputs only
  for (genvar e = 0; e < N_EXP; e++) begin : g_exp
    pt_term #(.N_LIT(N_IN)) u_exp (
      .fuse_i(cfg[e*EXP_FW +: EXP_FW]),
      .lit_i (in_i),
      .term_o(exp_term[e])
    );
    assign exp_n[e] = ~exp_term[e];

    p_exp_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg[e*EXP_FW +: EXP_FW] == '0) |-> !exp_n[e]);
  end

  assign lit_all = {exp_n, in_i};

  // second pass: macrocell terms see inputs and inverted expanders
  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    localparam int BASE = EXP_BITS + m * MC_BITS;
    pt_macrocell #(.N_LIT(N_LIT), .N_TERM(N_TERM)) u_mc (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .fuse_i(cfg[BASE +: MC_FW]),
      .inv_i (cfg[BASE + MC_FW]),
      .byp_i (cfg[BASE + MC_FW + 1]),
      .lit_i (lit_all),
      .out_o (out_o[m])
    );
  end
endmodule

// File: tb/sim_pt_macro_array.sv
module sim_pt_macro_array;
  localparam int N_IN = 8, N_MC = 4, N_EXP = 4, N_TERM = 3;
  localparam int N_LIT = N_IN + N_EXP;
  localparam int EXP_BITS = N_EXP * 2 * N_IN;
  localparam int MC_BITS = N_TERM * 2 * N_LIT + 2;
  localparam int CFG_W = EXP_BITS + N_MC * MC_BITS;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_en_i = 1'b0;
  logic cfg_din_i = 1'b0;
  logic [N_IN-1:0] in_i = '0;
  logic [N_MC-1:0] out_o;

  logic [CFG_W-1:0] cfg_v;
  int n_tests = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  pt_macro_array u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_en_i(cfg_en_i), .cfg_din_i(cfg_din_i),
    .in_i(in_i), .out_o(out_o)
  );

  function automatic int exp_off(int e, int j);
    return e * 2 * N_IN + 2 * j;
  endfunction
  function automatic int mc_base(int m);
    return EXP_BITS + m * MC_BITS;
  endfunction
  function automatic int lit_off(int m, int t, int j);
    return mc_base(m) + t * 2 * N_LIT + 2 * j;
  endfunction
  function automatic int inv_off(int m);
    return mc_base(m) + N_TERM * 2 * N_LIT;
  endfunction

  function automatic logic apply_lit(logic acc, logic [1:0] code, logic v);
    case (code)
      2'b01:   return acc & v;
      2'b10:   return acc & ~v;
      2'b11:   return 1'b0;
      default: return acc;
    endcase
  endfunction

  function automatic logic [N_MC-1:0] model(logic [CFG_W-1:0] c, logic [N_IN-1:0] x);
    logic [N_LIT-1:0] l;
    logic [N_MC-1:0] r;
    l[N_IN-1:0] = x;
    for (int e = 0; e < N_EXP; e++) begin
      logic p;
      p = 1'b1;
      for (int j = 0; j < N_IN; j++) p = apply_lit(p, c[exp_off(e, j) +: 2], x[j]);
      l[N_IN+e] = ~p;
    end
    for (int m = 0; m < N_MC; m++) begin
      logic s;
      s = 1'b0;
      for (int t = 0; t < N_TERM; t++) begin
        logic p;
        p = 1'b1;
        for (int j = 0; j < N_LIT; j++) p = apply_lit(p, c[lit_off(m, t, j) +: 2], l[j]);
        s = s | p;
      end
      r[m] = s ^ c[inv_off(m)];
    end
    return r;
  endfunction

  function automatic logic [N_MC-1:0] byp_mask(logic [CFG_W-1:0] c);
    logic [N_MC-1:0] b;
    for (int m = 0; m < N_MC; m++) b[m] = c[inv_off(m) + 1];
    return b;
  endfunction

  task automatic chk(string req, logic [N_MC-1:0] act, logic [N_MC-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%b exp=%b in=%h", req, act, exp, in_i);
    end
  endtask

  task automatic load_cfg();
    for (int i = 0; i < CFG_W; i++) begin
      @(negedge clk);
      cfg_en_i = 1'b1;
      cfg_din_i = cfg_v[i];
    end
    @(negedge clk);
    cfg_en_i = 1'b0;
  endtask

  // bypassed bits checked before the edge, registered bits after it
  task automatic apply_vec(logic [N_IN-1:0] x, string req);
    logic [N_MC-1:0] e, b;
    @(negedge clk);
    in_i = x;
    cfg_din_i = 1'($urandom);
    e = model(cfg_v, x);
    b = byp_mask(cfg_v);
    #1 chk(req, out_o & b, e & b);
    @(posedge clk);
    #1 chk(req, out_o & ~b, e & ~b);
  endtask

  function automatic logic [1:0] rnd_fuse();
    int r;
    r = int'($urandom % 32);
    if (r < 23) return 2'b00;
    if (r < 27) return 2'b01;
    if (r < 31) return 2'b10;
    return 2'b11;
  endfunction

  initial begin
    #(8 * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R8 outputs low in reset", out_o, 4'b0000);
    rst_ni = 1'b1;
    @(posedge clk);
    #1 chk("R3 cleared chain gives all ones", out_o, 4'b1111);

    // directed: folded function with expanders, and complement with inversion
    cfg_v = '0;
    cfg_v[exp_off(0, 0) +: 2] = 2'b01;
    cfg_v[exp_off(0, 1) +: 2] = 2'b01;
    cfg_v[exp_off(1, 0) +: 2] = 2'b10;
    cfg_v[exp_off(1, 2) +: 2] = 2'b01;
    cfg_v[exp_off(3, 6) +: 2] = 2'b01;
    cfg_v[exp_off(3, 7) +: 2] = 2'b01;
    cfg_v[lit_off(0, 0, 8) +: 2] = 2'b01;
    cfg_v[lit_off(0, 0, 2) +: 2] = 2'b01;
    cfg_v[lit_off(0, 0, 3) +: 2] = 2'b01;
    cfg_v[lit_off(0, 1, 9) +: 2] = 2'b01;
    cfg_v[lit_off(0, 1, 1) +: 2] = 2'b01;
    cfg_v[lit_off(0, 2, 0) +: 2] = 2'b11;
    cfg_v[inv_off(0) + 1] = 1'b1;
    for (int j = 0; j < 4; j++) cfg_v[lit_off(1, 0, j) +: 2] = 2'b01;
    cfg_v[lit_off(1, 1, 0) +: 2] = 2'b10;
    cfg_v[lit_off(1, 1, 3) +: 2] = 2'b10;
    cfg_v[lit_off(1, 2, 0) +: 2] = 2'b10;
    cfg_v[lit_off(1, 2, 2) +: 2] = 2'b10;
    cfg_v[inv_off(1)] = 1'b1;
    cfg_v[lit_off(2, 0, 4) +: 2] = 2'b01;
    cfg_v[lit_off(2, 0, 5) +: 2] = 2'b10;
    cfg_v[lit_off(2, 1, 7) +: 2] = 2'b11;
    cfg_v[lit_off(2, 2, 1) +: 2] = 2'b11;
    cfg_v[inv_off(2) + 1] = 1'b1;
    cfg_v[lit_off(3, 0, 10) +: 2] = 2'b01;
    cfg_v[lit_off(3, 1, 11) +: 2] = 2'b10;
    cfg_v[lit_off(3, 2, 6) +: 2] = 2'b11;
    load_cfg();
    for (int x = 0; x < 256; x++) begin
      logic a, b, c, d, f1, f2;
      apply_vec(8'(x), "R1 R2 R4 R5 R9 directed");
      {d, c, b, a} = 4'(x);
      f1 = (~a & c & d) | (~b & c & d) | (a & b) | (b & ~c);
      f2 = (a & ~b) | (a & ~c) | (a & ~d) | (~a & c & d);
      chk("R5 expander fold", {3'b000, out_o[0]}, {3'b000, f1});
      chk("R6 inverted complement", {3'b000, out_o[1]}, {3'b000, f2});
    end

    // random configurations
    for (int k = 0; k < 6; k++) begin
      for (int e = 0; e < N_EXP; e++)
        for (int j = 0; j < N_IN; j++) cfg_v[exp_off(e, j) +: 2] = rnd_fuse();
      for (int m = 0; m < N_MC; m++) begin
        for (int t = 0; t < N_TERM; t++)
          for (int j = 0; j < N_LIT; j++) cfg_v[lit_off(m, t, j) +: 2] = rnd_fuse();
        cfg_v[inv_off(m)] = 1'($urandom);
        cfg_v[inv_off(m) + 1] = 1'($urandom);
      end
      load_cfg();
      for (int v = 0; v < 200; v++) apply_vec(8'($urandom), "R1 R4 R6 R7 random");
    end

    // reset clears the loaded chain
    @(negedge clk);
    rst_ni = 1'b0;
    #1 chk("R8 reset mid run", out_o, 4'b0000);
    @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk);
    #1 chk("R8 chain cleared after reset", out_o, 4'b1111);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule